// File: doc/BRIEF.md
# Serial Result Readout Port with Frame Marker

This block forms the digital output side of a 16-bit sampling converter's serial port. It runs on an external, free-running data clock. A conversion result is presented together with a busy flag that is low during conversion. The result is captured when the flag returns high. A host then reads the result over a single DATA line.

A read is framed by an active-low chip select (`cs_n`) and a read/convert select (`rd_cnv`). A read begins with a SYNC pulse that lasts one clock. The 16 result bits follow, most significant first. After the word, DATA replays the bits that arrived on the `tag_in` daisy-chain input, delayed by the word length. This lets several ports be chained onto one line.

A read is only possible once SYNC generation has been armed. Arming happens on any clock edge that is not a read edge: either `cs_n` is high, or `cs_n` and `rd_cnv` are both low.

The serial stream has no back-pressure. The receiver cannot stall it, and there is no ready signal. The only flow control is `cs_n` together with `rd_cnv`. Dropping out of the read state ends the stream at once, and the unread bits are lost.

Top module: `sro_readout`

## Requirements
- R1: While `rst_n` is low, `sync_out` and `data_out` are low. Both stay low until a read starts.
- R2: On a clock edge where `busy` is high and was low at the previous edge, `conv_result` is captured as the unread result. A later capture replaces an unread result, and the replaced word is never sent.
- R3: A read starts on an edge E only when all of these hold:
  - `cs_n` is low, `rd_cnv` is high and `busy` is high;
  - an unread result exists;
  - an arming edge (`cs_n` high, or `cs_n` low with `rd_cnv` low) has occurred since the previous read start.
  Otherwise no SYNC appears.
- R4: `sync_out` is high in the clock period that follows edge E. It is high for exactly one period. `data_out` is low during that period.
- R5: After edge E+k, for k from 1 to 16, `data_out` carries result bit 16-k. Bit 15 comes first and bit 0 last.
- R6: After edge E+16+j (j ≥ 1), `data_out` carries the value of `tag_in` sampled at edge E+j. This continues for as long as the read is held.
- R7: An edge with `cs_n` high or `rd_cnv` low ends a read in progress. `data_out` and `sync_out` are low after that edge.
- R8: Each captured result starts at most one read. A further read attempt without a new capture produces no SYNC, and DATA stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Free-running data clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_result | input | 16 | Conversion result, captured when `busy` rises |
| busy | input | 1 | Low during conversion, high when a result is ready |
| cs_n | input | 1 | Active-low chip select |
| rd_cnv | input | 1 | High selects read, low selects convert |
| tag_in | input | 1 | Daisy-chain input replayed after the result word |
| sync_out | output | 1 | One-clock frame marker before the result word |
| data_out | output | 1 | Serial data: result MSB first, then delayed `tag_in` |

## Verification
Every output is a register on the data clock. The bench changes inputs on the falling edge and reads outputs on the falling edge that follows each rising edge. This makes the rising edge that starts a read offset 0. SYNC is then due in the half-period after offset 0. Result bit 16-k is due after offset k. The TAG bit driven before offset j is due after offset 16+j. An abort is due after the first edge that sees the exit. Each check is indexed by this offset, and the TAG values are kept in a reference queue in the order they were driven.

// File: rtl/sro_pkg.sv
package sro_pkg;
  localparam int unsigned SRO_WORD_W = 16;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SYNC  = 2'd1,
    PH_SHIFT = 2'd2
  } rd_phase_t;
endpackage

// File: rtl/sro_capture.sv
// Holds the most recent conversion result and an unread flag.
module sro_capture #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] result_i,
  input  logic              consume_i,
  output logic [WORD_W-1:0] word_o,
  output logic              fresh_o
);
  logic busy_q;
  logic busy_rise;

  assign busy_rise = busy_i & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b1;
      word_o  <= '0;
      fresh_o <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (busy_rise) begin
        word_o  <= result_i;
        fresh_o <= 1'b1;
      end else if (consume_i) begin
        fresh_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sro_arm.sv
// Remembers that a non-read edge occurred since the last read start.
module sro_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_edge_i,
  input  logic consume_i,
  output logic armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
    end else if (arm_edge_i) begin
      armed_o <= 1'b1;
    end else if (consume_i) begin
      armed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sro_shifter.sv
// Output bit register plus a chain that drains the word and fills from tag.
module sro_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tag_i,
  output logic              data_o
);
  localparam int unsigned TOP = WORD_W - 1;

  logic [TOP:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= 1'b0;
      chain_q <= '0;
    end else if (clear_i) begin
      data_o  <= 1'b0;
      chain_q <= '0;
    end else if (load_i) begin
      data_o  <= word_i[TOP];
      chain_q <= {word_i[TOP-1:0], tag_i};
    end else if (shift_i) begin
      data_o  <= chain_q[TOP];
      chain_q <= {chain_q[TOP-1:0], tag_i};
    end
  end
endmodule

// File: rtl/sro_readout.sv
module sro_readout #(
  parameter int unsigned WORD_W = sro_pkg::SRO_WORD_W
) (
  input  logic              dclk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] conv_result,
  input  logic              busy,
  input  logic              cs_n,
  input  logic              rd_cnv,
  input  logic              tag_in,
  output logic              sync_out,
  output logic              data_out
);
  import sro_pkg::*;

  rd_phase_t         phase_q;
  logic              read_sel;
  logic              start;
  logic              armed;
  logic              fresh;
  logic [WORD_W-1:0] held_word;

  assign read_sel = ~cs_n & rd_cnv;
  assign start    = (phase_q == PH_IDLE) & read_sel & busy & armed & fresh;

  sro_capture #(.WORD_W(WORD_W)) u_capture (
    .clk      (dclk),
    .rst_n    (rst_n),
    .busy_i   (busy),
    .result_i (conv_result),
    .consume_i(start),
    .word_o   (held_word),
    .fresh_o  (fresh)
  );

  sro_arm u_arm (
    .clk       (dclk),
    .rst_n     (rst_n),
    .arm_edge_i(~read_sel),
    .consume_i (start),
    .armed_o   (armed)
  );

  sro_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (dclk),
    .rst_n  (rst_n),
    .clear_i(~read_sel),
    .load_i (phase_q == PH_SYNC),
    .shift_i(phase_q == PH_SHIFT),
    .word_i (held_word),
    .tag_i  (tag_in),
    .data_o (data_out)
  );

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      sync_out <= 1'b0;
    end else begin
      sync_out <= start;
      if (!read_sel) begin
        phase_q <= PH_IDLE;
      end else begin
        unique case (phase_q)
          PH_IDLE:  if (start) phase_q <= PH_SYNC;
          PH_SYNC:  phase_q <= PH_SHIFT;
          default:  phase_q <= PH_SHIFT;
        endcase
      end
    end
  end
endmodule

// File: rtl/sro_readout_chk.sv
module sro_readout_chk (
  input logic dclk,
  input logic rst_n,
  input logic busy,
  input logic cs_n,
  input logic rd_cnv,
  input logic sync_out,
  input logic data_out
);
  logic busy_d;
  logic synced;

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d <= 1'b1;
      synced <= 1'b0;
    end else begin
      busy_d <= busy;
      if (busy && !busy_d) synced <= 1'b0;
      else if (sync_out)   synced <= 1'b1;
    end
  end

  a_r4_sync_single: assert property (@(posedge dclk) disable iff (!rst_n)
    sync_out |=> !sync_out);

  a_r4_sync_data_low: assert property (@(posedge dclk) disable iff (!rst_n)
    sync_out |-> !data_out);

  a_r3_sync_needs_read: assert property (@(posedge dclk) disable iff (!rst_n)
    sync_out |-> $past(busy && !cs_n && rd_cnv));

  a_r7_exit_clears: assert property (@(posedge dclk) disable iff (!rst_n)
    (cs_n || !rd_cnv) |=> (!sync_out && !data_out));

  a_r8_one_sync_per_capture: assert property (@(posedge dclk) disable iff (!rst_n)
    sync_out |-> !synced);
endmodule

bind sro_readout sro_readout_chk u_chk (
  .dclk    (dclk),
  .rst_n   (rst_n),
  .busy    (busy),
  .cs_n    (cs_n),
  .rd_cnv  (rd_cnv),
  .sync_out(sync_out),
  .data_out(data_out)
);

// File: tb/sro_readout_bench.sv
module sro_readout_bench;
  localparam int W  = 16;
  localparam int NT = 8;

  localparam logic [31:0] VECS [0:5] = '{
    32'hA5C3_00F1, 32'h0000_FFFF, 32'hFFFF_0000,
    32'h8001_5A5A, 32'h1234_C3A5, 32'h7FFE_0F0F
  };

  logic         dclk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] conv_result = '0;
  logic         busy = 1'b1;
  logic         cs_n = 1'b0;
  logic         rd_cnv = 1'b1;
  logic         tag_in = 1'b0;
  logic         sync_out;
  logic         data_out;

  int nchk = 0;
  int nfail = 0;

  always #5 dclk = ~dclk;

  sro_readout u_sro_readout (
    .dclk(dclk), .rst_n(rst_n), .conv_result(conv_result), .busy(busy),
    .cs_n(cs_n), .rd_cnv(rd_cnv), .tag_in(tag_in),
    .sync_out(sync_out), .data_out(data_out)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic convert(input logic [W-1:0] w);
    @(negedge dclk); cs_n = 1'b0; rd_cnv = 1'b0; busy = 1'b0;
    repeat (3) @(negedge dclk);
    busy = 1'b1; conv_result = w;
    @(negedge dclk);
  endtask

  task automatic arm_and_select;
    @(negedge dclk); cs_n = 1'b1; rd_cnv = 1'b1;
    @(negedge dclk); cs_n = 1'b0; rd_cnv = 1'b1;
  endtask

  // Next rising edge is the start edge (offset 0).
  task automatic full_read(input logic [W-1:0] w, input logic [W-1:0] tp);
    logic tagq[$];
    for (int k = 0; k <= 16 + NT; k++) begin
      @(negedge dclk);
      if (k == 0) begin
        chk("R4 sync high", sync_out, 1'b1);
        chk("R4 data low in sync", data_out, 1'b0);
      end else if (k <= 16) begin
        chk("R4 sync single", sync_out, 1'b0);
        chk("R5 word bit", data_out, w[16-k]);
      end else begin
        chk("R6 tag replay", data_out, tagq.pop_front());
      end
      tag_in = tp[k % W];
      tagq.push_back(tag_in);
    end
  endtask

  task automatic silent(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge dclk);
      chk(req, sync_out, 1'b0);
    end
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge dclk);
    chk("R1 sync in reset", sync_out, 1'b0);
    chk("R1 data in reset", data_out, 1'b0);
    rst_n = 1'b1;
    @(negedge dclk);
    chk("R1 data after reset", data_out, 1'b0);

    // R3: capture while read held from reset, never armed -> no sync
    busy = 1'b0;
    repeat (3) @(negedge dclk);
    busy = 1'b1; conv_result = 16'hC0DE;
    silent("R3 unarmed no sync", 6);
    arm_and_select;
    full_read(16'hC0DE, 16'h00FF);

    // R8: holding the read after a full frame gives no new sync
    silent("R8 no repeat sync", 4);

    // Back-to-back vector reads (R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      convert(VECS[v][31:16]);
      arm_and_select;
      full_read(VECS[v][31:16], VECS[v][15:0]);
    end

    // R8: re-read with no new capture
    arm_and_select;
    for (int i = 0; i < 5; i++) begin
      @(negedge dclk);
      chk("R8 no sync on reread", sync_out, 1'b0);
      chk("R8 data low on reread", data_out, 1'b0);
    end

    // R2: second capture replaces unread first
    convert(16'h1111);
    convert(16'hBEEF);
    arm_and_select;
    full_read(16'hBEEF, 16'hA5A5);

    // R7: abort mid-read
    convert(16'hFFFF);
    arm_and_select;
    @(negedge dclk);
    chk("R7 sync before abort", sync_out, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      @(negedge dclk);
      chk("R7 bits before abort", data_out, 1'b1);
    end
    cs_n = 1'b1;
    @(negedge dclk);
    chk("R7 data low after abort", data_out, 1'b0);
    chk("R7 sync low after abort", sync_out, 1'b0);
    cs_n = 1'b0; rd_cnv = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge dclk);
      chk("R8 aborted result not resent", sync_out, 1'b0);
      chk("R7 data stays low", data_out, 1'b0);
    end

    // R3: busy low blocks a read even when armed with an unread result
    convert(16'h4242);
    @(negedge dclk); busy = 1'b0; cs_n = 1'b1; rd_cnv = 1'b1;
    @(negedge dclk); cs_n = 1'b0;
    silent("R3 busy low no sync", 4);
    cs_n = 1'b1; busy = 1'b1;
    @(negedge dclk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule